// File: doc/BRIEF.md
# Serial DAC write controller

This block is the host-side master for a 16-bit serial-input digital-to-analog converter. A 16-bit code enters through a valid/ready stream port. The block then drives an active-low chip-select, a serial clock and a serial data line. Every interval on those lines is a whole number of system-clock cycles, and each interval is set by a parameter. The defaults suit a 125 MHz system clock. They give a 104 ns serial clock period with a 48 ns high phase and a 56 ns low phase. Chip-select falls 48 ns before the first rising edge, and the power-up wait is 20 µs.

The code is sent most significant bit first, one bit per rising edge of the serial clock. Data moves only on falling edges, so the whole low phase serves as setup time. When the per-word `strobe_mode` input is high at acceptance, an active-low load strobe is pulsed after chip-select has returned high. This supports converters that copy their input register to the output only on that strobe.

Back-pressure rule: `in_ready` is high only when the block is idle. A word moves on the rising clock edge where `in_valid` and `in_ready` are both high. While `in_ready` is low, `in_data` and `strobe_mode` may change freely and are not looked at. A producer may keep `in_valid` high, and its word is then taken on the first cycle that `in_ready` is high.

Top module: `dac_ser_writer`

## Requirements
- R1: While `rst_n` is low the outputs are: `dac_cs_n`=1, `dac_sck`=0, `dac_sdo`=0, `dac_ld_n`=1, `busy`=1, `in_ready`=0 and `done`=0.
- R2: After `rst_n` rises, `in_ready` stays low for exactly PWRUP_CYC rising clock edges and rises after edge number PWRUP_CYC. No chip-select falling edge occurs before that point.
- R3: A word is accepted only on an edge where `in_valid` and `in_ready` are both high. Exactly one frame follows each accepted word. A `in_valid` pulse that ends while `in_ready` is low produces no frame.
- R4: Each frame has exactly DATA_W rising serial-clock edges, all while `dac_cs_n` is low. The bits sampled on those edges, most significant first, equal the accepted code.
- R5: The first rising serial-clock edge comes exactly CS_SETUP_CYC cycles after chip-select falls.
- R6: Each serial-clock high phase lasts exactly SCK_HI_CYC cycles. Each low phase between two rising edges lasts exactly SCK_LO_CYC cycles.
- R7: Inside a frame, `dac_sdo` changes only in the cycle where the serial clock falls. It is therefore stable during every high phase.
- R8: While `dac_cs_n` is high, `dac_sck` and `dac_sdo` are both low.
- R9: Chip-select rises exactly SCK_LO_CYC cycles after the last falling serial-clock edge of the frame.
- R10: If `strobe_mode` was 1 at acceptance, `dac_ld_n` falls exactly STB_DELAY_CYC cycles after chip-select rises and stays low for exactly STB_WIDTH_CYC cycles. If it was 0, `dac_ld_n` stays high. `dac_ld_n` is never low while chip-select is low.
- R11: `done` is a one-cycle pulse. It appears in the cycle chip-select rises when `strobe_mode` was 0, and in the cycle `dac_ld_n` returns high when it was 1.
- R12: `in_ready` rises exactly CS_GAP_CYC cycles after `done`. Chip-select therefore stays high for at least CS_GAP_CYC cycles between frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Producer offers a code |
| in_ready | output | 1 | Block can take a code this cycle |
| in_data | input | DATA_W | Code to send |
| strobe_mode | input | 1 | 1: pulse the load strobe after this word's frame |
| dac_cs_n | output | 1 | Converter chip-select, active low |
| dac_sck | output | 1 | Serial clock, idles low |
| dac_sdo | output | 1 | Serial data, MSB first |
| dac_ld_n | output | 1 | Load strobe, active low |
| busy | output | 1 | Power-up wait, frame, strobe or gap in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
Two events can share one cycle: the end of the inter-frame gap and the acceptance of the next word. The bench provokes this by streaming a vector table back to back with `in_valid` held high, so each new word is taken on the same edge that `in_ready` rises. The bench judges this by timing the next chip-select fall against the previous `done` pulse, and by rebuilding every word from the serial line. A second case offers a word only while the block is busy and withdraws it before `in_ready` rises. It is judged by counting chip-select frames against words accepted.

// File: rtl/dac_wr_pkg.sv
package dac_wr_pkg;

  typedef enum logic [3:0] {
    ST_PWRUP,
    ST_IDLE,
    ST_SETUP,
    ST_SCKH,
    ST_SCKL,
    ST_TAIL,
    ST_STBW,
    ST_STBP,
    ST_GAP
  } wr_state_t;

endpackage

// File: rtl/dac_wr_timer.sv
module dac_wr_timer #(
  parameter int CNT_W   = 12,
  parameter int RST_VAL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= CNT_W'(RST_VAL);
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // a running interval never skips a count
  AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R6

endmodule

// File: rtl/dac_wr_shifter.sv
module dac_wr_shifter #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_word,
  input  logic              shift,
  output logic              sdo,
  output logic              last
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [DATA_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
    end else if (load) begin
      sh  <= load_word;
      cnt <= '0;
    end else if (shift) begin
      sh  <= {sh[DATA_W-2:0], 1'b0};
      cnt <= last ? '0 : cnt + 1'b1;
    end
  end

  assign sdo  = sh[DATA_W-1];
  assign last = (cnt == CNT_W'(DATA_W - 1));

  // after the final bit leaves, the line returns to zero
  AST_EMPTY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && last && !load) |=> (sh == '0)); // R8

endmodule

// File: rtl/dac_ser_writer.sv
module dac_ser_writer
  import dac_wr_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int PWRUP_CYC     = 2500,
  parameter int CS_SETUP_CYC  = 6,
  parameter int SCK_HI_CYC    = 6,
  parameter int SCK_LO_CYC    = 7,
  parameter int CS_GAP_CYC    = 13,
  parameter int STB_DELAY_CYC = 7,
  parameter int STB_WIDTH_CYC = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              strobe_mode,
  output logic              dac_cs_n,
  output logic              dac_sck,
  output logic              dac_sdo,
  output logic              dac_ld_n,
  output logic              busy,
  output logic              done
);

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAX_CYC = max2(max2(max2(PWRUP_CYC, CS_SETUP_CYC), max2(SCK_HI_CYC, SCK_LO_CYC)),
                                max2(CS_GAP_CYC, max2(STB_DELAY_CYC, STB_WIDTH_CYC)));
  localparam int TMR_W   = $clog2(MAX_CYC + 1);

  wr_state_t        state, state_nx;
  logic             tmr_load, tmr_zero;
  logic [TMR_W-1:0] tmr_val;
  logic             accept, shift, last_bit, mode_q;
  logic             sdo_int;

  assign busy     = (state != ST_IDLE);
  assign in_ready = !busy;
  assign accept   = in_valid && (state == ST_IDLE);
  assign shift    = (state == ST_SCKH) && tmr_zero;

  dac_wr_timer #(
    .CNT_W  (TMR_W),
    .RST_VAL(PWRUP_CYC - 1)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .zero    (tmr_zero)
  );

  dac_wr_shifter #(
    .DATA_W(DATA_W)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_word(in_data),
    .shift    (shift),
    .sdo      (sdo_int),
    .last     (last_bit)
  );

  assign dac_sdo = sdo_int;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_PWRUP: if (tmr_zero) state_nx = ST_IDLE;
      ST_IDLE:  if (in_valid) state_nx = ST_SETUP;
      ST_SETUP: if (tmr_zero) state_nx = ST_SCKH;
      ST_SCKH:  if (tmr_zero) state_nx = last_bit ? ST_TAIL : ST_SCKL;
      ST_SCKL:  if (tmr_zero) state_nx = ST_SCKH;
      ST_TAIL:  if (tmr_zero) state_nx = mode_q ? ST_STBW : ST_GAP;
      ST_STBW:  if (tmr_zero) state_nx = ST_STBP;
      ST_STBP:  if (tmr_zero) state_nx = ST_GAP;
      ST_GAP:   if (tmr_zero) state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_comb begin
    tmr_load = (state_nx != state);
    unique case (state_nx)
      ST_SETUP: tmr_val = TMR_W'(CS_SETUP_CYC - 1);
      ST_SCKH:  tmr_val = TMR_W'(SCK_HI_CYC - 1);
      ST_SCKL:  tmr_val = TMR_W'(SCK_LO_CYC - 1);
      ST_TAIL:  tmr_val = TMR_W'(SCK_LO_CYC - 1);
      ST_STBW:  tmr_val = TMR_W'(STB_DELAY_CYC - 1);
      ST_STBP:  tmr_val = TMR_W'(STB_WIDTH_CYC - 1);
      ST_GAP:   tmr_val = TMR_W'(CS_GAP_CYC - 1);
      default:  tmr_val = '0;
    endcase
  end

  // pin levels are registered decodes of the next state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_PWRUP;
      mode_q   <= 1'b0;
      dac_cs_n <= 1'b1;
      dac_sck  <= 1'b0;
      dac_ld_n <= 1'b1;
      done     <= 1'b0;
    end else begin
      state    <= state_nx;
      if (accept) mode_q <= strobe_mode;
      dac_cs_n <= !(state_nx inside {ST_SETUP, ST_SCKH, ST_SCKL, ST_TAIL});
      dac_sck  <= (state_nx == ST_SCKH);
      dac_ld_n <= (state_nx != ST_STBP);
      done     <= (state_nx == ST_GAP) && (state != ST_GAP);
    end
  end

  AST_SCK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    dac_sck |-> !dac_cs_n); // R4

  AST_ACCEPT_OPENS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!dac_cs_n && busy)); // R3

  AST_SDO_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_sck && $past(dac_sck)) |-> $stable(dac_sdo)); // R7

  AST_QUIET_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    dac_cs_n |-> (!dac_sdo && !dac_sck)); // R8

  AST_STROBE_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_ld_n |-> dac_cs_n); // R10

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11

  AST_DONE_THEN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy); // R12

endmodule

// File: tb/tb_dac_ser_writer.sv
module tb_dac_ser_writer;

  localparam int DATA_W = 16;
  localparam int PWRUP  = 2500;
  localparam int CSS    = 6;
  localparam int SHI    = 6;
  localparam int SLO    = 7;
  localparam int GAP    = 13;
  localparam int SDLY   = 7;
  localparam int SWID   = 7;
  localparam int NVEC   = 8;

  // {strobe_mode, code}
  localparam logic [16:0] VEC [0:NVEC-1] = '{
    {1'b0, 16'h0000}, {1'b1, 16'hFFFF}, {1'b0, 16'h8000}, {1'b1, 16'h0001},
    {1'b1, 16'hA5A5}, {1'b0, 16'h5A5A}, {1'b0, 16'h8555}, {1'b1, 16'h7FFF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic strobe_mode = 1'b0;
  logic in_ready, dac_cs_n, dac_sck, dac_sdo, dac_ld_n, busy, done;

  always #4 clk = ~clk;

  dac_ser_writer #(
    .DATA_W(DATA_W), .PWRUP_CYC(PWRUP), .CS_SETUP_CYC(CSS), .SCK_HI_CYC(SHI),
    .SCK_LO_CYC(SLO), .CS_GAP_CYC(GAP), .STB_DELAY_CYC(SDLY), .STB_WIDTH_CYC(SWID)
  ) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .strobe_mode(strobe_mode), .dac_cs_n(dac_cs_n),
    .dac_sck(dac_sck), .dac_sdo(dac_sdo), .dac_ld_n(dac_ld_n),
    .busy(busy), .done(done)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;
  bit mon_en = 1'b0;

  logic [15:0] exp_word [0:31];
  logic        exp_mode [0:31];
  int n_sent = 0;
  int n_fall = 0;
  int n_done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;

  // edge monitor, sampled away from the active edge
  logic p_cs = 1'b1, p_sck = 1'b0, p_sdo = 1'b0, p_ld = 1'b1, p_done = 1'b0, p_rdy = 1'b0;
  int t_cs_fall = 0, t_cs_rise = 0, t_rise = 0, t_sfall = 0, t_ld_fall = 0, t_done = 0;
  int nbits = 0, cur = 0;
  bit first_bit = 1'b0;
  logic [15:0] word = '0;

  always @(negedge clk) begin
    if (mon_en) begin
      if (p_cs && !dac_cs_n) begin
        if (n_fall == 0) chk(cyc >= PWRUP, "R2 first frame after wait", cyc, PWRUP);
        else chk(cyc - t_cs_rise >= GAP, "R12 chip-select gap", cyc - t_cs_rise, GAP);
        cur = n_fall; n_fall++; nbits = 0; word = '0; first_bit = 1'b1; t_cs_fall = cyc;
      end
      if (!p_sck && dac_sck) begin
        chk(!dac_cs_n, "R4 clock inside frame", dac_cs_n, 0);
        if (first_bit) chk(cyc - t_cs_fall == CSS, "R5 select setup", cyc - t_cs_fall, CSS);
        else chk(cyc - t_sfall == SLO, "R6 low phase", cyc - t_sfall, SLO);
        first_bit = 1'b0;
        word = {word[14:0], dac_sdo};
        nbits++;
        t_rise = cyc;
      end
      if (p_sck && !dac_sck) begin
        chk(cyc - t_rise == SHI, "R6 high phase", cyc - t_rise, SHI);
        t_sfall = cyc;
      end
      if (!dac_cs_n && !p_cs && dac_sdo != p_sdo)
        chk(p_sck && !dac_sck, "R7 data moves on falling edge", dac_sck, 0);
      if (dac_cs_n && (dac_sdo || dac_sck))
        chk(1'b0, "R8 idle lines", {dac_sck, dac_sdo}, 0);
      if (!p_cs && dac_cs_n) begin
        chk(nbits == DATA_W, "R4 bit count", nbits, DATA_W);
        chk(word == exp_word[cur], "R4 reassembled word", word, exp_word[cur]);
        chk(cyc - t_sfall == SLO, "R9 select hold", cyc - t_sfall, SLO);
        t_cs_rise = cyc;
      end
      if (p_ld && !dac_ld_n) begin
        chk(exp_mode[cur] == 1'b1, "R10 strobe only in strobe mode", 1, exp_mode[cur]);
        chk(cyc - t_cs_rise == SDLY, "R10 strobe delay", cyc - t_cs_rise, SDLY);
        chk(dac_cs_n, "R10 strobe outside frame", dac_cs_n, 1);
        t_ld_fall = cyc;
      end
      if (!p_ld && dac_ld_n)
        chk(cyc - t_ld_fall == SWID, "R10 strobe width", cyc - t_ld_fall, SWID);
      if (done) begin
        chk(!p_done, "R11 single-cycle done", p_done, 0);
        if (exp_mode[cur]) chk(!p_ld && dac_ld_n, "R11 done at strobe end", dac_ld_n, 1);
        else chk(!p_cs && dac_cs_n, "R11 done at select rise", dac_cs_n, 1);
        n_done++;
        t_done = cyc;
      end
      if (!p_rdy && in_ready && n_done > 0)
        chk(cyc - t_done == GAP, "R12 ready after done", cyc - t_done, GAP);
    end
    p_cs = dac_cs_n; p_sck = dac_sck; p_sdo = dac_sdo; p_ld = dac_ld_n;
    p_done = done; p_rdy = in_ready;
  end

  task automatic send(input logic mode, input logic [15:0] data);
    @(negedge clk);
    in_valid = 1'b1; in_data = data; strobe_mode = mode;
    while (!in_ready) @(negedge clk);
    exp_word[n_sent] = data;
    exp_mode[n_sent] = mode;
    n_sent++;
    @(posedge clk);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!in_ready || busy) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(dac_cs_n == 1'b1, "R1 cs_n in reset", dac_cs_n, 1);
    chk(dac_sck == 1'b0 && dac_sdo == 1'b0, "R1 sck/sdo in reset", {dac_sck, dac_sdo}, 0);
    chk(dac_ld_n == 1'b1, "R1 ld_n in reset", dac_ld_n, 1);
    chk(busy && !in_ready && !done, "R1 busy/ready/done in reset", {busy, in_ready, done}, 3'b100);
    rst_n = 1'b1;
    mon_en = 1'b1;
    // R2 power-up wait, valid offered from the start
    in_valid = 1'b1; in_data = 16'hC3C3;
    @(negedge clk);
    while (!in_ready) begin
      if (!dac_cs_n) chk(1'b0, "R2 frame during wait", cyc, PWRUP);
      @(negedge clk);
    end
    chk(cyc == PWRUP, "R2 ready after wait", cyc, PWRUP);
    in_valid = 1'b0;

    // vector table streamed back to back
    for (int i = 0; i < NVEC; i++) send(VEC[i][16], VEC[i][15:0]);
    @(negedge clk);
    in_valid = 1'b0;
    wait_idle();
    chk(n_fall == NVEC, "R3 one frame per vector", n_fall, NVEC);
    chk(n_done == NVEC, "R11 one done per vector", n_done, NVEC);

    // R3 a word withdrawn while busy is ignored
    send(1'b0, 16'h1234);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (60) @(negedge clk);
    in_valid = 1'b1; in_data = 16'hDEAD;
    @(negedge clk);
    in_valid = 1'b0; in_data = 16'h0000;
    wait_idle();
    repeat (300) @(negedge clk);
    chk(n_fall == n_sent, "R3 withdrawn word gives no frame", n_fall, n_sent);
    chk(dac_cs_n && dac_ld_n, "R3 lines idle afterwards", {dac_cs_n, dac_ld_n}, 2'b11);

    // strobe mode isolated, then plain mode
    send(1'b1, 16'h0F0F);
    @(negedge clk); in_valid = 1'b0;
    wait_idle();
    send(1'b0, 16'hF0F0);
    @(negedge clk); in_valid = 1'b0;
    wait_idle();
    chk(n_fall == n_sent && n_done == n_sent, "R11 totals", n_done, n_sent);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R3 actual=%0d expected=%0d", n_fall, n_sent);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule